// File: doc/BRIEF.md
# Card UART Status Flags and Interrupt Request

This block holds the status byte of a smart-card UART and produces the active-low interrupt request. Seven sticky event flags (framing error, overrun, parity error, early answer and three time-outs) are set by single-cycle pulses from the UART and timer logic. An eighth flag marks a transmit buffer that is empty or a receive buffer that is full, and software can mask it.

Software reads the status byte with a read strobe. The flags that were set when the strobe rose are cleared a fixed number of clocks later. The buffer flag clears on its own a fixed number of clocks after a transmit-data write or a receive-data read, or at once when the link turns from transmit to receive. A credit output tells software when that clear window has passed, so it does not have to count clocks.

All outputs are registered and change on the rising clock edge. Reset is synchronous and active high.

Top module: `uart_irq_status`

## Requirements
- R1: A pulse on `evt_i[b]` sampled at a clock edge sets `status_o[b]` after that edge, and the bit stays set until a status read clears it. The bit order is 0 framing, 1 overrun, 2 parity, 3 early answer, 4 to 6 time-outs 1 to 3.
- R2: `irq_n_o` is low in every cycle in which any of `status_o[6:0]` is 1. It changes at the same edge as the status bits.
- R3: `buf_set_i` sets `status_o[7]`, the buffer flag. While the flag is 1, `irq_n_o` is low if `buf_mask_i` was 0 at the last edge. When `buf_mask_i` was 1, the flag still reads 1 but has no effect on `irq_n_o`.
- R4: If `stat_rd_i` is seen rising at edge k (high at k, low at k-1), the event bits that were 1 before edge k are cleared after edge k+2. Bits first set at or after edge k are not cleared by that read. Holding the strobe high starts no further clear.
- R5: If an event pulse for a bit arrives at any edge from k to k+2 of a pending read clear, that bit is not cleared and reads 1 afterwards.
- R6: A `tx_wr_i` or `rx_rd_i` pulse at edge k clears the buffer flag after edge k+3. Another access inside the window restarts it.
- R7: `to_rx_i` at an edge clears the buffer flag after that edge.
- R8: `buf_set_i` wins over every clear of the buffer flag at the same edge.
- R9: `credit_o` goes low after the edge of a data access and goes high again after edge k+3, the same edge at which the buffer flag clears.
- R10: After reset, `status_o` is 0, `irq_n_o` is 1 and `credit_o` is 1.
- R11: A status read never clears the buffer flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 7 | Event pulses, one per sticky flag |
| buf_set_i | input | 1 | Sets the buffer flag |
| stat_rd_i | input | 1 | Status register read strobe |
| tx_wr_i | input | 1 | Transmit data register write strobe |
| rx_rd_i | input | 1 | Receive data register read strobe |
| to_rx_i | input | 1 | Pulse when the link turns from transmit to receive |
| buf_mask_i | input | 1 | Masks the buffer flag from the interrupt |
| status_o | output | 8 | Status byte: bits 6:0 events, bit 7 buffer flag |
| irq_n_o | output | 1 | Interrupt request, active low |
| credit_o | output | 1 | High when no buffer-flag clear window is open |

## Verification
An event, a buffer set, a direction change and a mask change all show on the outputs one edge after they are sampled. A status read clears its snapshot two edges after the rising strobe, and a data access clears the buffer flag three edges after it. The bench drives its inputs on the falling edge and steps a cycle model from the requirements after each rising edge. It compares all outputs on the next falling edge, so each result is checked in exactly the cycle it is due. Directed sequences place events on each edge of the read window and accesses on each edge of the buffer window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int EVT_W  = 7;
  localparam int STAT_W = EVT_W + 1;
  localparam int BUF_BIT = EVT_W;
  localparam int CLR_DLY_DEF = 2;
  localparam int BUF_DLY_DEF = 3;
  typedef enum logic [2:0] {
    EV_FRAME = 3'd0, EV_OVRUN = 3'd1, EV_PARITY = 3'd2, EV_EARLY = 3'd3,
    EV_TMO1  = 3'd4, EV_TMO2  = 3'd5, EV_TMO3   = 3'd6
  } evt_idx_e;
endpackage

// File: rtl/uis_evt_flags.sv
module uis_evt_flags #(
  parameter int N = 7,
  parameter int CLR_DELAY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         rd_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] flags_d_o
);
  logic         rd_q;
  logic         rise;
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic [CLR_DELAY-1:0][N-1:0] pipe_q;

  assign rise = rd_i & ~rd_q;
  // pending clears are dropped for any bit that sees a fresh event
  assign flags_d = (flags_q & ~pipe_q[CLR_DELAY-1]) | evt_i;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= rise ? (flags_q & ~evt_i) : '0;
      for (int s = 1; s < CLR_DELAY; s++)
        pipe_q[s] <= pipe_q[s-1] & ~evt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flags_o   = flags_q;
  assign flags_d_o = flags_d;

  for (genvar b = 0; b < N; b++) begin : g_bit
    // R1: an event pulse leaves its bit set
    a_r1_event_sets: assert property (@(posedge clk) disable iff (rst)
      evt_i[b] |=> flags_q[b]);
    // R5: a fresh event is never lost to a pending clear
    a_r5_event_kept: assert property (@(posedge clk) disable iff (rst)
      (evt_i[b] && pipe_q[CLR_DELAY-1][b]) |=> flags_q[b]);
  end

  // R4: a due clear removes its bits unless an event re-arms them
  a_r4_read_clear: assert property (@(posedge clk) disable iff (rst)
    (|pipe_q[CLR_DELAY-1]) |=>
      ((flags_q & $past(pipe_q[CLR_DELAY-1]) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/uis_buf_flag.sv
module uis_buf_flag #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_i,
  input  logic rd_i,
  input  logic to_rx_i,
  output logic buf_o,
  output logic buf_d_o,
  output logic credit_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic buf_q, buf_d, credit_q;
  logic access, fin, clr;

  assign access = wr_i | rd_i;
  assign fin    = (cnt_q == CW'(1)) & ~access;
  assign clr    = fin | to_rx_i;
  assign buf_d  = set_i ? 1'b1 : (clr ? 1'b0 : buf_q);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (access)      cnt_q <= CW'(DELAY);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) buf_q <= 1'b0;
    else     buf_q <= buf_d;
  end

  always_ff @(posedge clk) begin
    if (rst)         credit_q <= 1'b1;
    else if (access) credit_q <= 1'b0;
    else if (fin)    credit_q <= 1'b1;
  end

  assign buf_o    = buf_q;
  assign buf_d_o  = buf_d;
  assign credit_o = credit_q;

  a_r6_window_clear: assert property (@(posedge clk) disable iff (rst)
    (fin && !set_i) |=> !buf_q);
  a_r7_dir_clear: assert property (@(posedge clk) disable iff (rst)
    (to_rx_i && !set_i) |=> !buf_q);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> buf_q);
  a_r9_credit_drop: assert property (@(posedge clk) disable iff (rst)
    access |=> !credit_q);
endmodule

// File: rtl/uis_irq_gen.sv
module uis_irq_gen #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_d_i,
  input  logic         buf_d_i,
  input  logic         mask_i,
  output logic         irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~((|flags_d_i) | (buf_d_i & ~mask_i));
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int CLR_DELAY = CLR_DLY_DEF,
  parameter int BUF_DELAY = BUF_DLY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              buf_set_i,
  input  logic              stat_rd_i,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  input  logic              to_rx_i,
  input  logic              buf_mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_n_o,
  output logic              credit_o
);
  logic [EVT_W-1:0] flags, flags_d;
  logic buf_flag, buf_d;

  uis_evt_flags #(.N(EVT_W), .CLR_DELAY(CLR_DELAY)) u_evt (
    .clk(clk), .rst(rst), .evt_i(evt_i), .rd_i(stat_rd_i),
    .flags_o(flags), .flags_d_o(flags_d));

  uis_buf_flag #(.DELAY(BUF_DELAY)) u_buf (
    .clk(clk), .rst(rst), .set_i(buf_set_i), .wr_i(tx_wr_i), .rd_i(rx_rd_i),
    .to_rx_i(to_rx_i), .buf_o(buf_flag), .buf_d_o(buf_d), .credit_o(credit_o));

  uis_irq_gen #(.N(EVT_W)) u_irq (
    .clk(clk), .rst(rst), .flags_d_i(flags_d), .buf_d_i(buf_d),
    .mask_i(buf_mask_i), .irq_n_o(irq_n_o));

  assign status_o = {buf_flag, flags};

  a_r2_irq_on_event: assert property (@(posedge clk) disable iff (rst)
    (|status_o[BUF_BIT-1:0]) |-> !irq_n_o);
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (status_o == {1'b1, {EVT_W{1'b0}}} && !$past(buf_mask_i)) |-> !irq_n_o);
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (status_o == '0 && irq_n_o && credit_o));
endmodule

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] evt = '0;
  logic bset = 0, rd = 0, wr = 0, rrd = 0, torx = 0, mask = 0;
  logic [7:0] status;
  logic irq_n, credit;

  int checks = 0, fails = 0, cyc = 0;
  logic done = 0;

  // reference state
  logic [6:0] m_ev;
  int m_pend [7];
  logic m_buf, m_credit, m_irq_n, m_rd_q;
  int m_cnt;

  always #5 clk = ~clk;

  uart_irq_status uut (
    .clk(clk), .rst(rst), .evt_i(evt), .buf_set_i(bset), .stat_rd_i(rd),
    .tx_wr_i(wr), .rx_rd_i(rrd), .to_rx_i(torx), .buf_mask_i(mask),
    .status_o(status), .irq_n_o(irq_n), .credit_o(credit));

  task automatic model_step();
    logic rise, access, fin;
    logic [6:0] old_ev;
    if (rst) begin
      m_ev = '0; m_buf = 0; m_credit = 1; m_irq_n = 1; m_rd_q = 0; m_cnt = 0;
      for (int b = 0; b < 7; b++) m_pend[b] = 0;
      return;
    end
    rise = rd && !m_rd_q;
    old_ev = m_ev;
    for (int b = 0; b < 7; b++) begin
      if (evt[b]) begin m_ev[b] = 1; m_pend[b] = 0; end
      else if (m_pend[b] == 1) begin m_ev[b] = 0; m_pend[b] = 0; end
      else if (m_pend[b] > 1) m_pend[b]--;
      if (rise && old_ev[b] && !evt[b]) m_pend[b] = 2;
    end
    access = wr || rrd;
    fin = (m_cnt == 1) && !access;
    if (access) begin m_cnt = 3; m_credit = 0; end
    else if (m_cnt > 0) m_cnt--;
    if (fin) m_credit = 1;
    if (bset) m_buf = 1;
    else if (fin || torx) m_buf = 0;
    m_irq_n = !((|m_ev) || (m_buf && !mask));
    m_rd_q = rd;
  endtask

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (status,irq_n,credit)", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk); #1 model_step();
    @(negedge clk);
    cyc++;
    check(tag, {status, irq_n, credit}, {m_buf, m_ev, m_irq_n, m_credit});
  endtask

  task automatic idle();
    evt = '0; bset = 0; rd = 0; wr = 0; rrd = 0; torx = 0;
  endtask

  task automatic kval(string tag, logic [7:0] exp_s);
    checks++;
    if (status !== exp_s) begin
      fails++;
      $display("FAIL %s: status %h expected %h", tag, status, exp_s);
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    @(negedge clk);
    tick("R10 reset"); tick("R10 reset");
    rst = 0;
    kval("R10 reset status", 8'h00);
    check("R10 reset outs", {2'b00, status, irq_n, credit}, {10'b0000000011});

    // R1 / R2: parity pulse
    evt = 7'b0000100; tick("R1 set"); idle();
    kval("R1 parity bit", 8'h04);
    tick("R1 sticky"); kval("R1 sticky", 8'h04);
    check("R2 irq low", {9'b0, irq_n}, 10'b0);

    // R4: read clear timing, strobe held high
    evt = 7'b1000000; rd = 1; tick("R4 rise");  // bit 6 set at rise edge: kept
    evt = '0; tick("R4 window");
    kval("R4 not yet", 8'h44);
    tick("R4 cleared"); kval("R4 cleared", 8'h40);
    tick("R4 held strobe"); kval("R4 held strobe", 8'h40);
    rd = 0; tick("R4 fall");

    // R5: event in window on each edge offset
    for (int off = 0; off < 3; off++) begin
      rd = 1; if (off == 0) evt = 7'b1000000;
      tick("R5 win0"); rd = 0; evt = (off == 1) ? 7'b1000000 : '0;
      tick("R5 win1"); evt = (off == 2) ? 7'b1000000 : '0;
      tick("R5 win2"); evt = '0;
      tick("R5 after"); kval("R5 kept", 8'h40);
    end
    rd = 1; tick("R4 drain"); rd = 0; tick("R4 drain"); tick("R4 drain");
    kval("R4 empty", 8'h00);

    // R3: buffer flag with mask
    bset = 1; tick("R3 set"); bset = 0;
    check("R3 irq unmasked", {status, irq_n, credit}, {8'h80, 2'b01});
    mask = 1; tick("R3 mask");
    check("R3 irq masked", {status, irq_n, credit}, {8'h80, 2'b11});
    // R11: status read keeps buffer flag
    rd = 1; tick("R11 rd"); rd = 0; tick("R11"); tick("R11"); tick("R11");
    kval("R11 buffer kept", 8'h80);

    // R6 / R9: write starts window
    wr = 1; tick("R6 acc"); wr = 0;
    check("R9 credit low", {9'b0, credit}, 10'b0);
    tick("R6 w1"); tick("R6 w2"); kval("R6 still set", 8'h80);
    tick("R6 cleared"); kval("R6 cleared", 8'h00);
    check("R9 credit back", {9'b0, credit}, 10'b1);

    // R6 restart by receive read inside the window
    bset = 1; rrd = 1; tick("R6 restart"); bset = 0; rrd = 0;
    tick("R6 r1"); rrd = 1; tick("R6 r2"); rrd = 0;
    tick("R6 r3"); kval("R6 restarted", 8'h80);
    tick("R6 r4"); tick("R6 r5"); kval("R6 late clear", 8'h00);

    // R7 and R8
    bset = 1; tick("R7 prep"); bset = 0; torx = 1; tick("R7 dir");
    torx = 0; kval("R7 dir clear", 8'h00);
    bset = 1; torx = 1; tick("R8 set wins"); idle(); kval("R8 set wins", 8'h80);
    mask = 0;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      r = $urandom();
      evt  = (r[3:0] == 0) ? 7'(1 << ($urandom() % 7)) : '0;
      bset = (r[7:4] == 0);
      rd   = (r[10:8] < 2) ? 1'b1 : ((r[10:8] == 7) ? rd : 1'b0);
      wr   = (r[14:11] == 0);
      rrd  = (r[18:15] == 0);
      torx = (r[23:19] == 0);
      if (r[31:27] == 0) mask = ~mask;
      tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    idle();
    tick("R2 final");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule